// File: doc/BRIEF.md
# Programmable Third-Order Sinc Decimator

This block turns the one-bit output of a delta-sigma modulator into signed 24-bit words. A divider on the system clock sets the modulator clock rate. Every 128th modulator clock tick, the block raises a sample strobe. The external modulator steps on that strobe, and the filter takes in the modulator bit at the same edge. A cascaded integrator-comb filter of order three then decimates by a programmable ratio and rescales each result to a 24-bit two's-complement word.

Software supplies an 11-bit decimation setting `deci_val`. The ratio is that value plus one, so it runs from 1 to 2048. The divider setting `div_val` makes the modulator clock tick once every `div_val + 1` system cycles. New settings are adopted only at the end of a decimation period. Each word comes with a one-cycle ready pulse and a flag that tells whether the filter history behind it is complete. Dropping `en` puts the block into a cleared idle state.

Top module: `sinc3_decimator`

## Requirements
- R1: While `rst_n` or `en` is low, `sample_stb`, `word_rdy` and `word_settled` stay 0 and `word_out` reads 0. All counters and filter state are cleared, so the next enable starts from an empty history.
- R2: While enabled, the modulator clock tick recurs every div+1 system cycles, where div is the adopted divider setting. `sample_stb` is high on every 128th tick, so strobes are 128×(div+1) cycles apart.
- R3: `mod_bit` is taken at the rising edge where `sample_stb` is high. A 1 enters the filter as +1 and a 0 enters it as −1.
- R4: `word_rdy` is a single-cycle pulse in the cycle after the strobe that closes each group of deci+1 samples. The first pulse comes 128×(div+1)×(deci+1) cycles after `en` rises. `word_out` changes only in a cycle with `word_rdy` high.
- R5: Each word is S = Σ x[n−a−b−c] over a, b, c in [0, R), where R = deci+1 and n is the last sample of the period. S is multiplied by 2^(23−3L), where L = ceil(log2 R), or arithmetically shifted right by 3L−23 when 3L > 23. The result saturates to [−8388608, 8388607].
- R6: `word_settled` accompanies each word. It is 0 for the first three words after an enable or after a new ratio is adopted, and 1 from the fourth on.
- R7: A change of `deci_val` or `div_val` while enabled is adopted when the current decimation period ends. The word that closes that period still uses the old ratio. While disabled, the inputs are adopted at once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| en | input | 1 | Run enable; low clears and idles the block |
| div_val | input | 8 | Modulator clock divider setting (period = value + 1 cycles) |
| deci_val | input | 11 | Decimation setting (ratio = value + 1) |
| mod_bit | input | 1 | Modulator output bit |
| sample_stb | output | 1 | Sample strobe for the modulator, one cycle wide |
| word_out | output | 24 | Filtered signed output word |
| word_rdy | output | 1 | One-cycle pulse marking a new word |
| word_settled | output | 1 | High when the word rests on a full filter history |

## Verification
Every result has a fixed due time. The first ready pulse comes exactly 128×(div+1)×(deci+1) cycles after the enable, and each later pulse comes exactly that many cycles after the one before. After a mid-period setting change, the next pulse is still due at the old period's end. The bench counts falling edges from the enable, from the previous pulse or from the setting change, and compares that count with the expected gap. It reads the word and the settled flag on the falling edge where `word_rdy` is seen. It follows `sample_stb` so that each modulator bit it records matches the bit the filter takes in one edge later.

// File: rtl/sinc3_pkg.sv
package sinc3_pkg;

  // Filter order and the strobe divisor shared by all units
  localparam int ORDER_DEF  = 3;
  localparam int OSR_DEF    = 128;
  localparam int SETTLE_CNT = 3;

  // Number of significant bits of a value; for v = R-1 this equals ceil(log2 R)
  function automatic int unsigned bit_len(input logic [31:0] v);
    int unsigned n;
    n = 0;
    for (int i = 0; i < 32; i++) begin
      if (v[i]) n = i + 1;
    end
    return n;
  endfunction

endpackage

// File: rtl/sinc3_mclk_div.sv
module sinc3_mclk_div #(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic [DIV_W-1:0] div_act,
  output logic             mclk_en
);

  logic [DIV_W-1:0] cnt_q;

  assign mclk_en = run && (cnt_q >= div_act);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (!run || mclk_en) begin
      cnt_q <= '0;
    end else begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

endmodule

// File: rtl/sinc3_sample_tick.sv
module sinc3_sample_tick #(
  parameter int OSR = 128
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  input  logic mclk_en,
  output logic stb
);

  localparam int CW = (OSR > 1) ? $clog2(OSR) : 1;
  localparam logic [CW-1:0] LAST = CW'(OSR - 1);

  logic [CW-1:0] cnt_q;

  assign stb = run && mclk_en && (cnt_q == LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (!run) begin
      cnt_q <= '0;
    end else if (mclk_en) begin
      cnt_q <= (cnt_q == LAST) ? '0 : cnt_q + 1'b1;
    end
  end

endmodule

// File: rtl/sinc3_core.sv
module sinc3_core
  import sinc3_pkg::*;
#(
  parameter int DECI_W = 11,
  parameter int OUT_W  = 24,
  parameter int ORDER  = 3
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    run,
  input  logic                    stb,
  input  logic                    mod_bit,
  input  logic [DECI_W-1:0]       deci_act,
  input  logic                    ratio_chg,
  output logic                    period_end,
  output logic signed [OUT_W-1:0] word_q,
  output logic                    rdy_q,
  output logic                    settled_q
);

  // One sign bit, one headroom bit, ORDER*DECI_W growth bits
  localparam int ACC_W  = ORDER * DECI_W + 2;
  localparam int WIDE_W = ACC_W + OUT_W;
  localparam logic signed [WIDE_W-1:0] W_MAX = {{(ACC_W + 1){1'b0}}, {(OUT_W - 1){1'b1}}};
  localparam logic signed [WIDE_W-1:0] W_MIN = {{(ACC_W + 1){1'b1}}, {(OUT_W - 1){1'b0}}};

  // Rescale a raw filter sum to the output width with saturation
  function automatic logic signed [OUT_W-1:0] scale_word(
    input logic signed [ACC_W-1:0] v,
    input int unsigned             l
  );
    logic signed [WIDE_W-1:0] w;
    int sh;
    w  = WIDE_W'(v);
    sh = ORDER * int'(l);
    if (sh <= OUT_W - 1) w = w <<< (OUT_W - 1 - sh);
    else                 w = w >>> (sh - (OUT_W - 1));
    if (w > W_MAX) return W_MAX[OUT_W-1:0];
    if (w < W_MIN) return W_MIN[OUT_W-1:0];
    return w[OUT_W-1:0];
  endfunction

  logic signed [ACC_W-1:0] integ_q [ORDER];
  logic signed [ACC_W-1:0] integ_nx[ORDER];
  logic signed [ACC_W-1:0] dly_q   [ORDER];
  logic signed [ACC_W-1:0] comb_v  [ORDER];
  logic signed [ACC_W-1:0] x_pm;
  logic [DECI_W-1:0]       dcnt_q;
  logic [1:0]              wcnt_q;

  assign x_pm       = mod_bit ? ACC_W'(1) : {ACC_W{1'b1}};
  assign period_end = stb && (dcnt_q >= deci_act);

  // Integrator chain: each stage adds the fresh value of the stage before
  always_comb begin
    integ_nx[0] = integ_q[0] + x_pm;
    for (int k = 1; k < ORDER; k++) begin
      integ_nx[k] = integ_q[k] + integ_nx[k-1];
    end
  end

  // Comb chain at the decimated rate, delay of one decimated sample
  always_comb begin
    comb_v[0] = integ_nx[ORDER-1] - dly_q[0];
    for (int k = 1; k < ORDER; k++) begin
      comb_v[k] = comb_v[k-1] - dly_q[k];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int k = 0; k < ORDER; k++) begin
        integ_q[k] <= '0;
        dly_q[k]   <= '0;
      end
      dcnt_q    <= '0;
      wcnt_q    <= '0;
      word_q    <= '0;
      rdy_q     <= 1'b0;
      settled_q <= 1'b0;
    end else if (!run) begin
      for (int k = 0; k < ORDER; k++) begin
        integ_q[k] <= '0;
        dly_q[k]   <= '0;
      end
      dcnt_q    <= '0;
      wcnt_q    <= '0;
      word_q    <= '0;
      rdy_q     <= 1'b0;
      settled_q <= 1'b0;
    end else begin
      rdy_q <= period_end;
      if (stb) begin
        for (int k = 0; k < ORDER; k++) integ_q[k] <= integ_nx[k];
        dcnt_q <= period_end ? '0 : dcnt_q + 1'b1;
      end
      if (period_end) begin
        dly_q[0] <= integ_nx[ORDER-1];
        for (int k = 1; k < ORDER; k++) dly_q[k] <= comb_v[k-1];
        word_q    <= scale_word(comb_v[ORDER-1], bit_len(32'(deci_act)));
        settled_q <= (wcnt_q == 2'(SETTLE_CNT));
        if (ratio_chg)                       wcnt_q <= '0;
        else if (wcnt_q != 2'(SETTLE_CNT))   wcnt_q <= wcnt_q + 1'b1;
      end
    end
  end

endmodule

// File: rtl/sinc3_decimator.sv
module sinc3_decimator
  import sinc3_pkg::*;
#(
  parameter int DIV_W  = 8,
  parameter int DECI_W = 11,
  parameter int OUT_W  = 24,
  parameter int OSR    = OSR_DEF,
  parameter int ORDER  = ORDER_DEF
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    en,
  input  logic [DIV_W-1:0]        div_val,
  input  logic [DECI_W-1:0]       deci_val,
  input  logic                    mod_bit,
  output logic                    sample_stb,
  output logic signed [OUT_W-1:0] word_out,
  output logic                    word_rdy,
  output logic                    word_settled
);

  logic [DIV_W-1:0]  div_act;
  logic [DECI_W-1:0] deci_act;
  logic              mclk_en;
  logic              period_end;
  logic              ratio_chg;

  assign ratio_chg = (deci_val != deci_act);

  // Settings are adopted when idle or at a decimation boundary
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      div_act  <= '0;
      deci_act <= '0;
    end else if (!en || period_end) begin
      div_act  <= div_val;
      deci_act <= deci_val;
    end
  end

  sinc3_mclk_div #(.DIV_W(DIV_W)) u_div (
    .clk     (clk),
    .rst_n   (rst_n),
    .run     (en),
    .div_act (div_act),
    .mclk_en (mclk_en)
  );

  sinc3_sample_tick #(.OSR(OSR)) u_tick (
    .clk     (clk),
    .rst_n   (rst_n),
    .run     (en),
    .mclk_en (mclk_en),
    .stb     (sample_stb)
  );

  sinc3_core #(.DECI_W(DECI_W), .OUT_W(OUT_W), .ORDER(ORDER)) u_core (
    .clk        (clk),
    .rst_n      (rst_n),
    .run        (en),
    .stb        (sample_stb),
    .mod_bit    (mod_bit),
    .deci_act   (deci_act),
    .ratio_chg  (ratio_chg),
    .period_end (period_end),
    .word_q     (word_out),
    .rdy_q      (word_rdy),
    .settled_q  (word_settled)
  );

endmodule

// File: rtl/sinc3_decimator_chk.sv
module sinc3_decimator_chk #(
  parameter int OUT_W = 24
) (
  input logic                    clk,
  input logic                    rst_n,
  input logic                    en,
  input logic                    mclk_en,
  input logic                    sample_stb,
  input logic                    period_end,
  input logic                    word_rdy,
  input logic                    word_settled,
  input logic signed [OUT_W-1:0] word_out
);

  p_idle_clear_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> (!word_rdy && !word_settled && word_out == '0));

  p_stb_needs_en_r1: assert property (@(posedge clk) disable iff (!rst_n)
    sample_stb |-> en);

  p_stb_on_tick_r2: assert property (@(posedge clk) disable iff (!rst_n)
    sample_stb |-> mclk_en);

  p_stb_gap_r2: assert property (@(posedge clk) disable iff (!rst_n)
    sample_stb |=> !sample_stb);

  p_period_on_stb_r4: assert property (@(posedge clk) disable iff (!rst_n)
    period_end |-> sample_stb);

  p_rdy_after_stb_r4: assert property (@(posedge clk) disable iff (!rst_n)
    word_rdy |-> $past(sample_stb));

  p_rdy_pulse_r4: assert property (@(posedge clk) disable iff (!rst_n)
    word_rdy |=> !word_rdy);

  p_word_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (en && $past(en) && !word_rdy) |-> $stable(word_out));

  p_settle_with_word_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(word_settled) |-> word_rdy);

endmodule

bind sinc3_decimator sinc3_decimator_chk #(.OUT_W(OUT_W)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .en           (en),
  .mclk_en      (mclk_en),
  .sample_stb   (sample_stb),
  .period_end   (period_end),
  .word_rdy     (word_rdy),
  .word_settled (word_settled),
  .word_out     (word_out)
);

// File: tb/tb_sinc3_decimator.sv
`timescale 1ns/1ps
module tb_sinc3_decimator;

  localparam int HN     = 4096;
  localparam int WD_LIM = 190000;
  localparam longint FS_P = 8388607;
  localparam longint FS_N = -8388608;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        en = 1'b0;
  logic [7:0]  div_val = '0;
  logic [10:0] deci_val = '0;
  logic        mod_bit = 1'b0;
  logic        sample_stb;
  logic signed [23:0] word_out;
  logic        word_rdy;
  logic        word_settled;

  int checks = 0;
  int fails  = 0;
  int cyc    = 0;
  int mode   = 0;   // 0 ones, 1 zeros, 2 alternating, 3 random
  int ns     = 0;
  int hist [HN];
  bit stb_pend = 1'b0;

  always #2 clk = ~clk;

  sinc3_decimator dut (
    .clk(clk), .rst_n(rst_n), .en(en), .div_val(div_val), .deci_val(deci_val),
    .mod_bit(mod_bit), .sample_stb(sample_stb), .word_out(word_out),
    .word_rdy(word_rdy), .word_settled(word_settled)
  );

  // Modulator model and sample recorder, aligned on the strobe (R3)
  always @(negedge clk) begin
    cyc++;
    if (mode == 0) mod_bit = 1'b1;
    else if (mode == 1) mod_bit = 1'b0;
    else if (stb_pend) mod_bit = (mode == 2) ? ~mod_bit : 1'($urandom % 2);
    stb_pend = sample_stb;
    if (!en) ns = 0;
    if (sample_stb) begin
      hist[ns % HN] = mod_bit ? 1 : -1;
      ns++;
    end
  end

  task automatic summary();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
  endtask

  always @(negedge clk) begin
    if (cyc == WD_LIM) begin
      checks++; fails++;
      $display("FAIL watchdog R4: actual=%0d expected<%0d", cyc, WD_LIM);
      summary();
      $finish;
    end
  end

  task automatic chk(string req, string what, longint act, longint exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // Expected rescaling, restated with integer powers (R5)
  function automatic longint exp_word(longint v, int r);
    int l = 0; longint p = 1; longint e; int pw;
    while (p < r) begin p = p * 2; l++; end
    pw = 3 * l;
    if (pw <= 23) e = v * (longint'(1) << (23 - pw));
    else          e = v >>> (pw - 23);
    if (e > FS_P) e = FS_P;
    if (e < FS_N) e = FS_N;
    return e;
  endfunction

  // Direct triple-box sum over the recorded bits (R5)
  function automatic longint ref_sum(int r);
    longint s = 0;
    for (int a = 0; a < r; a++)
      for (int b = 0; b < r; b++)
        for (int c = 0; c < r; c++) begin
          int idx = ns - 1 - a - b - c;
          if (idx >= 0) s += hist[idx % HN];
        end
    return s;
  endfunction

  task automatic wait_rdy(output int gap);
    gap = 0;
    do begin @(negedge clk); gap++; end while (!word_rdy && gap < 100000);
  endtask

  task automatic start(int dv, int dc, int md);
    en = 1'b0;
    div_val = 8'(dv); deci_val = 11'(dc); mode = md;
    repeat (4) @(negedge clk);
    chk("R1", "idle rdy", word_rdy, 0);
    chk("R1", "idle word", word_out, 0);
    en = 1'b1;
  endtask

  task automatic run_const(int dv, int dc, int md, int nw, longint expv, string req);
    int g;
    start(dv, dc, md);
    for (int i = 1; i <= nw; i++) begin
      wait_rdy(g);
      chk("R4", "word gap", g, 128 * (dv + 1) * (dc + 1));
      chk("R6", "settled flag", word_settled, (i > 3) ? 1 : 0);
      if (i > 3) chk(req, "settled value", longint'(word_out), expv);
    end
    @(negedge clk);
    chk("R4", "rdy single cycle", word_rdy, 0);
  endtask

  initial begin
    int g;
    void'($urandom(32'd20240));
    repeat (3) @(negedge clk);
    chk("R1", "reset word", word_out, 0);
    chk("R1", "reset rdy", word_rdy, 0);
    chk("R1", "reset settled", word_settled, 0);
    rst_n = 1'b1;

    // Constant densities at several ratios (R3, R5)
    run_const(0, 3, 0, 4, exp_word(64, 4), "R3");
    chk("R5", "ones R=4 full scale", exp_word(64, 4), FS_P);
    run_const(0, 0, 0, 4, FS_P, "R5");
    run_const(0, 3, 1, 4, FS_N, "R3");
    run_const(0, 5, 0, 4, 3538944, "R5");
    run_const(0, 5, 2, 5, 0, "R5");
    run_const(0, 8, 1, 4, -1492992, "R5");
    // Divider setting (R2)
    run_const(2, 2, 0, 4, 3538944, "R2");

    // Mid-period ratio change (R7, R6)
    run_const(0, 3, 0, 4, FS_P, "R5");
    repeat (99) @(negedge clk);
    deci_val = 11'd2;
    wait_rdy(g);
    chk("R7", "gap closing old period", g, 412);
    chk("R7", "old-ratio word", longint'(word_out), FS_P);
    chk("R6", "old word still settled", word_settled, 1);
    for (int i = 1; i <= 4; i++) begin
      wait_rdy(g);
      chk("R7", "new ratio gap", g, 384);
      chk("R6", "settle after change", word_settled, (i > 3) ? 1 : 0);
    end
    chk("R7", "new ratio value", longint'(word_out), 3538944);

    // Mid-period divider change (R7, R2)
    repeat (50) @(negedge clk);
    div_val = 8'd1;
    wait_rdy(g);
    chk("R7", "gap before divider adopted", g, 334);
    wait_rdy(g);
    chk("R2", "gap with new divider", g, 768);

    // Disable mid-run (R1)
    repeat (100) @(negedge clk);
    en = 1'b0;
    begin
      int seen = 0;
      for (int i = 0; i < 800; i++) begin
        @(negedge clk);
        if (word_rdy || sample_stb || word_settled || word_out != 0) seen++;
      end
      chk("R1", "activity while disabled", seen, 0);
    end
    en = 1'b1;
    wait_rdy(g);
    chk("R4", "first gap after re-enable", g, 768);
    chk("R6", "settled cleared on re-enable", word_settled, 0);

    // Random bitstreams against the direct-sum reference (R5, R3)
    for (int t = 0; t < 3; t++) begin
      int dc = 1 + int'($urandom % 5);
      int dv = int'($urandom % 2);
      start(dv, dc, 3);
      for (int i = 1; i <= 7; i++) begin
        wait_rdy(g);
        chk("R4", "random gap", g, 128 * (dv + 1) * (dc + 1));
        if (i > 3) chk("R5", "random word", longint'(word_out), exp_word(ref_sum(dc + 1), dc + 1));
      end
    end

    en = 1'b0;
    repeat (4) @(negedge clk);
    summary();
    $finish;
  end

endmodule